// File: doc/BRIEF.md
# Decimal Counting Stage with Seven-Segment Drive

This block is one digit of a chained decimal counter-display. It keeps its count as a five-bit twisted-ring (Johnson) code that steps through ten states, and decodes that code directly into seven active-high segment drives for the digits 0 to 9. A carry output runs at one tenth of the count rate, so it can serve as the count clock of the next, more significant digit.

The count clock and the clock inhibit are asynchronous pins. They are passed through a synchronizer on a free-running system clock and edge-detected there, so every state change happens on the system clock. A rising count clock edge advances the digit while the inhibit is low. With the count clock held high, a falling edge on the inhibit also advances it, so the inhibit can act as a negative-edge clock. A clear input returns the digit to zero.

Digits are chained through a significance link so that leading and trailing zeros of a multi-digit number stay dark. For example, an eight-digit field holding 0050.0700 displays 50.07. Each stage passes on whether it, or something beyond it in the chain, showed a digit. A lamp test input lights every segment.

Top module: `decade_seg_stage`

## Requirements
- R1: After system reset `rst` the count is zero. With `sig_in` high and `lamp_test` low, `seg` then reads 7'h3F and `carry` is high.
- R2: The stored count code is always one of the ten Johnson patterns 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000, which stand for digits 0 to 9 in that order. Any other pattern is replaced by 00000 on the next advance.
- R3: `clear` high at a system clock edge sets the count to zero at that edge. This overrides any advance that falls in the same cycle.
- R4: A rising edge on `cnt_clk` while `cnt_inh` is low advances the digit by one, with 9 wrapping to 0. The new digit appears SYNC_STAGES+1 system clock edges after the pin changes.
- R5: Edges on `cnt_clk` while `cnt_inh` is high leave the digit unchanged.
- R6: A falling edge on `cnt_inh` while `cnt_clk` is high advances the digit by one.
- R7: `carry` is high for digits 0 to 4 and low for digits 5 to 9, so it rises on the wrap from 9 to 0.
- R8: `seg` bit 0 drives segment a and bit 6 drives segment g. Digits 0 to 9 give 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R9: When `sig_in` is low and the digit is 0, `seg` is 0 and `sig_out` is low. Otherwise `sig_out` is high.
- R10: `lamp_test` high forces `seg` to 7F, overriding blanking. `sig_out` is unaffected by it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Asynchronous active-high system reset |
| cnt_clk | input | 1 | Count clock pin (asynchronous) |
| cnt_inh | input | 1 | Count inhibit pin, also usable as a falling-edge count clock |
| clear | input | 1 | Synchronous return to zero |
| lamp_test | input | 1 | Lights all segments |
| sig_in | input | 1 | High when a neighbour in the chain is significant; low allows a zero here to be blanked |
| seg | output | 7 | Active-high segments, bit 0 = a through bit 6 = g |
| carry | output | 1 | Decade carry, high for digits 0 to 4 |
| sig_out | output | 1 | Low when this digit was blanked as a non-significant zero |

## Verification
A pin change on `cnt_clk` or `cnt_inh` shows up at `seg` and `carry` SYNC_STAGES+1 system clock edges later. `clear` acts at the next edge. `lamp_test` and `sig_in` reach `seg` and `sig_out` with no clock at all. The bench drives every pin just after a falling edge and waits SYNC_STAGES+2 rising edges before it samples at the next falling edge, so each sample lands after the last register on the path has settled. It tracks the digit in a model that is updated only by the pin sequences it has applied.

// File: rtl/decade_seg_stage.sv
module decade_seg_stage #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cnt_clk,
  input  logic       cnt_inh,
  input  logic       clear,
  input  logic       lamp_test,
  input  logic       sig_in,
  output logic [6:0] seg,
  output logic       carry,
  output logic       sig_out
);
  localparam int JW = 5;

  logic [SYNC_STAGES-1:0] ck_sync, ih_sync;
  logic ck_prev, ih_prev, ck_now, ih_now;
  logic adv, legal, blank;
  logic [JW-1:0] jc;
  logic [3:0] digit;
  logic [6:0] pattern;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ck_sync <= '0;
      ih_sync <= '0;
      ck_prev <= 1'b0;
      ih_prev <= 1'b0;
    end else begin
      ck_sync[0] <= cnt_clk;
      ih_sync[0] <= cnt_inh;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        ck_sync[i] <= ck_sync[i-1];
        ih_sync[i] <= ih_sync[i-1];
      end
      ck_prev <= ck_now;
      ih_prev <= ih_now;
    end
  end

  assign ck_now = ck_sync[SYNC_STAGES-1];
  assign ih_now = ih_sync[SYNC_STAGES-1];
  assign adv = (ck_now & ~ck_prev & ~ih_now) | (ck_now & ih_prev & ~ih_now);

  assign legal = $countones(jc[JW-2:0] ^ jc[JW-1:1]) <= 1;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)
      jc <= '0;
    else if (clear)
      jc <= '0;
    else if (adv)
      jc <= legal ? {jc[JW-2:0], ~jc[JW-1]} : '0;
  end

  always_comb begin
    if (jc[JW-1])
      digit = 4'(10 - $countones(jc));
    else
      digit = 4'($countones(jc));
  end

  always_comb begin
    case (digit)
      4'd0: pattern = 7'h3F;
      4'd1: pattern = 7'h06;
      4'd2: pattern = 7'h5B;
      4'd3: pattern = 7'h4F;
      4'd4: pattern = 7'h66;
      4'd5: pattern = 7'h6D;
      4'd6: pattern = 7'h7D;
      4'd7: pattern = 7'h07;
      4'd8: pattern = 7'h7F;
      4'd9: pattern = 7'h6F;
      default: pattern = 7'h00;
    endcase
  end

  assign blank   = ~sig_in & (digit == 4'd0);
  assign sig_out = ~blank;
  assign carry   = ~jc[JW-1];
  assign seg     = lamp_test ? 7'h7F : (blank ? 7'h00 : pattern);
endmodule

// File: rtl/decade_seg_stage_chk.sv
module decade_seg_stage_chk (
  input logic       clk,
  input logic       rst,
  input logic       clear,
  input logic       lamp_test,
  input logic       sig_in,
  input logic       adv,
  input logic [4:0] jc,
  input logic [6:0] seg,
  input logic       carry,
  input logic       sig_out
);
  logic [3:0] d;
  always_comb d = jc[4] ? 4'(10 - $countones(jc)) : 4'($countones(jc));

  p_legal_code_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(jc[3:0] ^ jc[4:1]) <= 1);

  p_clear_zero_r3: assert property (@(posedge clk) disable iff (rst)
    clear |=> (jc == 5'b0));

  p_step_one_r4: assert property (@(posedge clk) disable iff (rst)
    (adv && !clear) |=> (d == (($past(d) == 4'd9) ? 4'd0 : $past(d) + 4'd1)));

  p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clear) |=> $stable(jc));

  p_carry_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(carry) |-> (d == 4'd0));

  p_blank_dark_r9: assert property (@(posedge clk) disable iff (rst)
    (!sig_in && !lamp_test && d == 4'd0) |-> (seg == 7'h00 && !sig_out));

  p_lamp_all_r10: assert property (@(posedge clk) disable iff (rst)
    lamp_test |-> (seg == 7'h7F));
endmodule

bind decade_seg_stage decade_seg_stage_chk i_chk (
  .clk(clk), .rst(rst), .clear(clear), .lamp_test(lamp_test), .sig_in(sig_in),
  .adv(adv), .jc(jc), .seg(seg), .carry(carry), .sig_out(sig_out)
);

// File: tb/test_decade_seg_stage.sv
module test_decade_seg_stage;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_clk = 1'b0, cnt_inh = 1'b0, clear = 1'b0, lamp_test = 1'b0, sig_in = 1'b1;
  logic [6:0] seg;
  logic carry, sig_out;

  int checks = 0;
  int failures = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  decade_seg_stage #(.SYNC_STAGES(SYNC)) i_decade_seg_stage (
    .clk(clk), .rst(rst), .cnt_clk(cnt_clk), .cnt_inh(cnt_inh), .clear(clear),
    .lamp_test(lamp_test), .sig_in(sig_in), .seg(seg), .carry(carry), .sig_out(sig_out)
  );

  function automatic logic [6:0] pat(int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  function automatic logic [6:0] exp_seg(int d, logic lt, logic si);
    if (lt) return 7'h7F;
    if (!si && d == 0) return 7'h00;
    return pat(d);
  endfunction

  task automatic settle();
    repeat (SYNC + 2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_out(string req);
    logic [6:0] es;
    logic ec, eo;
    es = exp_seg(exp_cnt, lamp_test, sig_in);
    ec = (exp_cnt < 5);
    eo = !(!sig_in && exp_cnt == 0);
    checks++;
    if (seg !== es || carry !== ec || sig_out !== eo) begin
      failures++;
      $display("FAIL %s: seg=%h carry=%b sig_out=%b expected seg=%h carry=%b sig_out=%b (digit %0d)",
               req, seg, carry, sig_out, es, ec, eo, exp_cnt);
    end
  endtask

  task automatic count_pulse();
    cnt_clk = 1'b1; settle();
    cnt_clk = 1'b0; settle();
  endtask

  task automatic inhibited_pulse();
    cnt_inh = 1'b1; settle();
    cnt_clk = 1'b1; settle();
    cnt_clk = 1'b0; settle();
    cnt_inh = 1'b0; settle();
  endtask

  task automatic inh_edge_count();
    cnt_inh = 1'b1; settle();
    cnt_clk = 1'b1; settle();
    cnt_inh = 1'b0; settle();
    cnt_clk = 1'b0; settle();
  endtask

  task automatic clear_pulse();
    clear = 1'b1; @(negedge clk);
    clear = 1'b0; @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, got hung expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    check_out("R1");

    for (int i = 0; i < 10; i++) begin
      logic c_before;
      c_before = carry;
      count_pulse();
      exp_cnt = (exp_cnt + 1) % 10;
      check_out("R4");
      check_out("R8");
      if (exp_cnt == 0) begin
        checks++;
        if (!(c_before == 1'b0 && carry == 1'b1)) begin
          failures++;
          $display("FAIL R7: carry before/after wrap %b/%b expected 0/1", c_before, carry);
        end
      end else check_out("R7");
      check_out("R2");
    end

    count_pulse(); exp_cnt = 1;
    inhibited_pulse();
    check_out("R5");

    inh_edge_count(); exp_cnt = 2;
    check_out("R6");

    count_pulse(); exp_cnt = 3;
    clear_pulse(); exp_cnt = 0;
    check_out("R3");

    count_pulse(); count_pulse(); exp_cnt = 2;
    clear = 1'b1;
    count_pulse();
    clear = 1'b0; @(negedge clk);
    exp_cnt = 0;
    check_out("R3");

    sig_in = 1'b0; #1;
    check_out("R9");
    lamp_test = 1'b1; #1;
    check_out("R10");
    lamp_test = 1'b0;
    count_pulse(); exp_cnt = 1;
    check_out("R9");
    lamp_test = 1'b1; #1;
    check_out("R10");
    lamp_test = 1'b0; sig_in = 1'b1;

    for (int n = 0; n < 300; n++) begin
      int op;
      op = int'($urandom % 6);
      lamp_test = ($urandom % 5) == 0;
      sig_in = ($urandom % 2) == 1;
      case (op)
        0, 1: begin count_pulse(); exp_cnt = (exp_cnt + 1) % 10; check_out("R4"); end
        2: begin inhibited_pulse(); check_out("R5"); end
        3: begin inh_edge_count(); exp_cnt = (exp_cnt + 1) % 10; check_out("R6"); end
        4: begin clear_pulse(); exp_cnt = 0; check_out("R3"); end
        default: begin #1; check_out("R9"); end
      endcase
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule